// File: doc/BRIEF.md
# DMA Request and Wait-State Handshake Engine

This engine paces byte transfers between a byte-wide peripheral data port and an external DMA controller. It has two modes. In per-byte mode it raises a request whenever the bus side can move one byte, and the controller answers each request with an acknowledge and a read or write strobe. In block mode one request opens the transfer. The acknowledge then stays held, and the engine inserts wait states by pulling a ready line low until the next byte can be taken.

A transfer ends when software clears the enable bit or when the controller marks the final byte with an end-of-process signal. A phase mismatch reported by the bus side freezes the transfer and raises an interrupt. In block mode it also keeps ready low, so the only way to release the controller is to clear the enable bit. Each completed byte produces a one-cycle data latch pulse, which the bus side also uses as its consume strobe. The engine flags an acknowledge that arrives while the chip select is active.

Top module: `dma_handshake`

## Requirements
- R1: After reset, drq, latch_en, irq and cs_err are 0 and ready is 1.
- R2: In per-byte mode (blk_mode=0), drq is high exactly when dma_en=1, no stop or stall is pending, byte_rdy=1, dack=0, and latch_en=0. drq drops in the same cycle dack rises.
- R3: A byte completes when the strobe (rd_stb OR wr_stb) was high in the previous cycle, is low now, dack=1, and the transfer is running. latch_en pulses high for exactly the following cycle.
- R4: cs_err is high in the cycle after any cycle in which dack and cs are both 1, and low otherwise.
- R5: In block mode, drq may rise only before the first dack of the transfer. Once dack has been seen, drq stays low until the transfer ends or dma_en is cleared.
- R6: In block mode, after dack has been seen, ready is low in any cycle where byte_rdy=0 or latch_en=1, so the strobe is extended until the next byte can be taken.
- R7: A phase_mm pulse while running sets irq from the next cycle. irq then holds, drq stays low, and in an opened block transfer ready stays low, until dma_en is cleared.
- R8: While dma_en=0, ready is 1 and drq is 0 in that same cycle. irq, the stall and any stop are cleared on the next edge.
- R9: eop high together with an active strobe and dack marks that byte as final. The byte still completes with its latch_en pulse, and afterwards drq stays 0 and ready stays 1 until dma_en is cleared and set again.
- R10: ready is 1 whenever no block transfer has been opened by dack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | DMA mode enable bit |
| blk_mode | input | 1 | 1 selects block mode, 0 per-byte mode |
| dack | input | 1 | DMA acknowledge from the controller |
| cs | input | 1 | CPU chip select |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| eop | input | 1 | End of process, marks the final byte |
| byte_rdy | input | 1 | Bus side can move one byte |
| phase_mm | input | 1 | Bus phase mismatch |
| drq | output | 1 | DMA request |
| ready | output | 1 | Wait-state control, low inserts waits |
| latch_en | output | 1 | Data latch enable and consume pulse |
| irq | output | 1 | Interrupt on phase mismatch |
| cs_err | output | 1 | dack seen with cs active |

## Verification
The hardest state to reach is an opened block transfer that a phase mismatch stalls, with ready held low, followed by a clear of the enable bit that must release ready at once. Random stimulus rarely lines up an opening dack, a mismatch and a later enable drop in that order. A directed sequence therefore opens a block, strobes a byte, injects the mismatch and then drops dma_en. A second directed sequence marks a strobed byte with eop and checks that the byte still latches before the engine goes idle. Long random runs in both modes, with rare mismatches, eop pulses and enable drops, are compared cycle by cycle against a bench model.

// File: rtl/dma_handshake.sv
module dma_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_en,
  input  logic blk_mode,
  input  logic dack,
  input  logic cs,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic eop,
  input  logic byte_rdy,
  input  logic phase_mm,
  output logic drq,
  output logic ready,
  output logic latch_en,
  output logic irq,
  output logic cs_err
);

  logic strb, strb_q, run, done;
  logic eop_q, opened_q, stall_q, stopped_q, lat_q, err_q;

  assign strb = rd_stb | wr_stb;
  assign run  = dma_en & ~stopped_q;
  assign done = run & dack & strb_q & ~strb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb_q    <= 1'b0;
      lat_q     <= 1'b0;
      err_q     <= 1'b0;
      eop_q     <= 1'b0;
      opened_q  <= 1'b0;
      stall_q   <= 1'b0;
      stopped_q <= 1'b0;
    end else begin
      strb_q <= strb;
      lat_q  <= done;
      err_q  <= dack & cs;
      if (!dma_en) begin
        eop_q     <= 1'b0;
        opened_q  <= 1'b0;
        stall_q   <= 1'b0;
        stopped_q <= 1'b0;
      end else begin
        if (done)                          eop_q <= 1'b0;
        else if (run & dack & strb & eop)  eop_q <= 1'b1;
        if (done & eop_q)   stopped_q <= 1'b1;
        if (run & phase_mm) stall_q   <= 1'b1;
        opened_q <= run & blk_mode & (opened_q | dack);
      end
    end
  end

  assign drq      = run & ~stall_q & byte_rdy & ~dack & ~lat_q & ~(blk_mode & opened_q);
  assign ready    = ~(run & opened_q & (stall_q | ~byte_rdy | lat_q));
  assign latch_en = lat_q;
  assign irq      = stall_q;
  assign cs_err   = err_q;

  assert_drq_dack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> !drq);
  assert_latch_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |=> !latch_en);
  assert_cs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dack && cs) |=> cs_err);
  assert_blk_drq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opened_q && blk_mode) |-> !drq);
  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && dma_en) |=> irq);
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> (ready && !drq));
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_q && dma_en) |-> (!drq && ready));

endmodule

// File: tb/test_dma_handshake.sv
module test_dma_handshake;
  logic clk = 0, rst_n = 0;
  logic dma_en = 0, blk_mode = 0, dack = 0, cs = 0, rd_stb = 0, wr_stb = 0;
  logic eop = 0, byte_rdy = 0, phase_mm = 0;
  logic drq, ready, latch_en, irq, cs_err;
  int n_chk = 0, n_bad = 0;
  string tag = "";

  always #4 clk = ~clk;

  dma_handshake i_dma_handshake (.*);

  // bench model state
  bit m_sq, m_lat, m_err, m_eop, m_open, m_stall, m_stop;

  function automatic bit f_run(); return dma_en & ~m_stop; endfunction
  function automatic bit f_drq();
    if (!f_run() || m_stall || !byte_rdy || dack || m_lat) return 0;
    if (blk_mode && m_open) return 0;
    return 1;
  endfunction
  function automatic bit f_ready();
    if (!f_run() || !m_open) return 1;
    return !(m_stall || !byte_rdy || m_lat);
  endfunction

  task automatic chk(input bit act, input bit exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit s, dn;
    s = rd_stb | wr_stb;
    dn = f_run() & dack & m_sq & ~s;
    if (!rst_n) begin
      {m_sq, m_lat, m_err, m_eop, m_open, m_stall, m_stop} = '0;
      return;
    end
    if (!dma_en) begin
      m_eop = 0; m_open = 0; m_stall = 0; m_stop = 0;
    end else begin
      bit r;
      r = f_run();
      if (dn && m_eop) m_stop = 1;
      if (dn) m_eop = 0; else if (r && dack && s && eop) m_eop = 1;
      if (r && phase_mm) m_stall = 1;
      m_open = r & blk_mode & (m_open | dack);
    end
    m_lat = dn;
    m_err = dack & cs;
    m_sq = s;
  endtask

  // inputs already set after negedge: compare, then advance model at posedge
  task automatic step();
    #1;
    chk(drq, f_drq(), blk_mode ? "R5 drq" : "R2 drq");
    chk(ready, f_ready(), m_open ? "R6 ready" : "R10 ready");
    chk(latch_en, m_lat, "R3 latch_en");
    chk(irq, m_stall, "R7 irq");
    chk(cs_err, m_err, "R4 cs_err");
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    @(negedge clk);
    repeat (3) step();
    rst_n = 1;
    tag = "R1";
    #1;
    chk(drq, 0, "R1 drq"); chk(ready, 1, "R1 ready"); chk(latch_en, 0, "R1 latch_en");
    chk(irq, 0, "R1 irq"); chk(cs_err, 0, "R1 cs_err");
    @(negedge clk);

    // directed: eop on final byte, per-byte mode
    tag = "R9";
    dma_en = 1; byte_rdy = 1; step();
    chk(drq, 1, "R2 drq raised");
    dack = 1; step();
    rd_stb = 1; eop = 1; step();
    rd_stb = 0; eop = 0; step();
    #1 chk(latch_en, 1, "R9 final byte latched");
    dack = 0; step();
    step();
    #1 chk(drq, 0, "R9 drq idle after eop"); chk(ready, 1, "R9 ready idle");
    dma_en = 0; step();
    dma_en = 1; step();
    #1 chk(drq, 1, "R9 drq after re-enable");

    // directed: block mode stall then enable clear
    tag = "R7";
    blk_mode = 1; step();
    dack = 1; step();
    wr_stb = 1; step();
    wr_stb = 0; step();
    phase_mm = 1; step();
    phase_mm = 0; step();
    #1 chk(irq, 1, "R7 irq set"); chk(ready, 0, "R7 ready stalled");
    step(); step();
    #1 chk(ready, 0, "R7 ready still stalled");
    dma_en = 0;
    #1 chk(ready, 1, "R8 ready released same cycle"); chk(drq, 0, "R8 drq low");
    step();
    #1 chk(irq, 0, "R8 irq cleared");
    dack = 0; cs = 1; step();
    dack = 1; step();
    #1 chk(cs_err, 1, "R4 cs_err flagged");
    cs = 0; dack = 0; step();

    // random mixed traffic
    tag = "rnd";
    for (int seg = 0; seg < 40; seg++) begin
      blk_mode = $urandom_range(0, 1);
      dma_en = 0; step();
      dma_en = 1;
      for (int c = 0; c < 500; c++) begin
        byte_rdy = ($urandom_range(0, 3) != 0);
        if ($urandom_range(0, 3) == 0) dack = ~dack;
        rd_stb = dack & ($urandom_range(0, 2) == 0);
        wr_stb = dack & !rd_stb & ($urandom_range(0, 4) == 0);
        cs = ($urandom_range(0, 30) == 0);
        eop = ($urandom_range(0, 25) == 0);
        phase_mm = ($urandom_range(0, 300) == 0);
        if ($urandom_range(0, 120) == 0) dma_en = ~dma_en;
        step();
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule